// File: doc/BRIEF.md
# Serial flash command sequencer

This block issues one serial flash command at a time on a half-duplex SPI bus in mode 3. Software sets up a timing word, an address word and a data word, then writes a command word. The command word gives the opcode, the transfer direction, the number of address bytes, dummy bytes and data bytes, the select line to use, and whether that line stays low after the command ends. The engine sends the opcode, then the low address bytes most significant first, then zero-valued dummy bytes. It then sends or receives up to four data bytes.

A long flash operation is split into a chain of short commands under one held chip select. While the select is held from an earlier command, a new command leaves out its opcode and runs only its address, dummy and data phases. A command that has nothing to transfer and has keep-selected clear only releases the held line. A status word shows a busy flag and a sticky error flag. The error flag records a command write that arrived while the engine was busy.

Register indices on `reg_addr` are: 0 command, 1 address (bits 23:0), 2 data, 3 status, 4 timing. A read returns the selected register in the same cycle.

Top module: `sflash_seq`

## Requirements
- R1: After reset, `sck_o` is high, `mosi_o` is high, every `cs_n_o` bit is high and the status word reads 0.
- R2: The command word decodes as follows: opcode bits 7:0, write direction bit 8, data bytes bits 11:9, keep-selected bit 15, dummy bytes bits 19:16, address bytes bits 22:20 (values above 3 count as 3), select index bits 26:24. Bytes go out in this order: opcode, then the low address bytes most significant first, then 0x00 dummy bytes, then data. Within each byte the most significant bit is sent first.
- R3: On a write, the data bytes are taken from the data register starting with bits 7:0, then bits 15:8, and so on.
- R4: On a read, the first received data byte is stored in bits 7:0, the next in bits 15:8, and so on. Byte lanes beyond the data length keep their old value.
- R5: The select line chosen by the index goes low at the command write and stays low until the command completes. At most one line is ever low. With keep-selected set, the line stays low after completion. With keep-selected clear, it goes high at completion.
- R6: A command issued while a select line is held from an earlier command sends no opcode byte.
- R7: A command issued while a line is held, with zero address, dummy and data bytes and keep-selected clear, produces no SCK edge. It releases the line and clears busy one cycle after the write.
- R8: Status bit 22 is set from the accepting edge until completion. Status bit 29 is sticky: writing a 1 to bit 29 of the status register clears it, and writing a 0 leaves it set.
- R9: A command write while busy is ignored and sets bit 29. This includes a write in the very cycle the running command completes. The first command write after busy clears is accepted.
- R10: SCK idles high. Each SCK low half and each high half lasts H+1 clock cycles, where H is timing-register bits 3:0. Between bytes there is one extra high cycle. A command of T bytes keeps busy set for T*(16*(H+1)+1)+1 cycles. `mosi_o` changes only when SCK falls, and `miso_i` is sampled when SCK rises.
- R11: Writes to the address, data and timing registers while busy are ignored.
- R12: `hold_n_o` and `wp_n_o` are driven high at all times.
- R13: A data length field of 5, 6 or 7 is handled as 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| cs_n_o | output | 8 | Active-low select lines |
| hold_n_o | output | 1 | Hold line, kept high |
| wp_n_o | output | 1 | Write-protect line, kept high |

## Verification
The completion of a running command and the arrival of a new command write can fall in the same clock edge. At that edge busy is still set, so the new write must be refused and must set the error flag. The bench computes the completion edge from R10 and issues the second command write exactly on that edge. It then checks that the error flag is set, that the line is released, that no additional byte appears on the bus, and that a command written one cycle later is accepted.

// File: rtl/sflash_seq.sv
module sflash_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic [7:0]  cs_n_o,
  output logic        hold_n_o,
  output logic        wp_n_o
);
  localparam logic [2:0] A_CMD = 3'd0, A_ADDR = 3'd1, A_DATA = 3'd2, A_STAT = 3'd3, A_TIME = 3'd4;
  localparam int MAX_DATA = 4;
  localparam int MAX_ADDR = 3;

  typedef enum logic [1:0] {S_IDLE, S_START, S_LOW, S_HIGH} st_t;
  st_t st;

  logic [31:0] cmd_r, data_r;
  logic [23:0] addr_r;
  logic [3:0]  half_r, cnt;
  logic        pend, err, held, skip_op, mosi_r;
  logic [4:0]  byte_idx;
  logic [2:0]  bit_idx;
  logic [7:0]  rx_sh, cur_byte;

  wire [2:0] dl_f = cmd_r[11:9];
  wire [2:0] al_f = cmd_r[22:20];
  wire [4:0] dlen = (dl_f > 3'(MAX_DATA)) ? 5'(MAX_DATA) : {2'b0, dl_f};
  wire [4:0] alen = (al_f > 3'(MAX_ADDR)) ? 5'(MAX_ADDR) : {2'b0, al_f};
  wire [4:0] a0 = {4'b0, ~skip_op};
  wire [4:0] d0 = a0 + alen;
  wire [4:0] x0 = d0 + {1'b0, cmd_r[19:16]};
  wire [4:0] total = x0 + dlen;
  wire       is_wr = cmd_r[8];
  wire       keep = cmd_r[15];
  wire [4:0] k_addr = byte_idx - a0;
  wire [4:0] k_dat = byte_idx - x0;
  wire [1:0] ash = alen[1:0] - 2'd1 - k_addr[1:0];
  wire       last_tick = (cnt == half_r);

  always_comb begin
    if (byte_idx < a0)      cur_byte = cmd_r[7:0];
    else if (byte_idx < d0) begin
      case (ash)
        2'd0:    cur_byte = addr_r[7:0];
        2'd1:    cur_byte = addr_r[15:8];
        default: cur_byte = addr_r[23:16];
      endcase
    end
    else if (byte_idx < x0) cur_byte = 8'h00;
    else if (is_wr)         cur_byte = data_r[{k_dat[1:0], 3'b000} +: 8];
    else                    cur_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_r <= '0;
      data_r <= '0;
      addr_r <= '0;
      half_r <= 4'd1;
      cnt <= '0;
      pend <= 1'b0;
      err <= 1'b0;
      held <= 1'b0;
      skip_op <= 1'b0;
      mosi_r <= 1'b1;
      byte_idx <= '0;
      bit_idx <= '0;
      rx_sh <= '0;
    end else begin
      case (st)
        S_START: begin
          if (byte_idx == total) begin
            st <= S_IDLE;
            pend <= 1'b0;
            held <= keep;
          end else begin
            st <= S_LOW;
            cnt <= '0;
            mosi_r <= cur_byte[7];
          end
        end
        S_LOW: begin
          if (last_tick) begin
            st <= S_HIGH;
            cnt <= '0;
            rx_sh <= {rx_sh[6:0], miso_i};
          end else cnt <= cnt + 4'd1;
        end
        S_HIGH: begin
          if (last_tick) begin
            cnt <= '0;
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
              st <= S_START;
              byte_idx <= byte_idx + 5'd1;
              if (byte_idx >= x0 && !is_wr) data_r[{k_dat[1:0], 3'b000} +: 8] <= rx_sh;
            end else begin
              st <= S_LOW;
              mosi_r <= cur_byte[3'd6 - bit_idx];
            end
          end else cnt <= cnt + 4'd1;
        end
        default: ;
      endcase
      if (reg_we) begin
        case (reg_addr)
          A_CMD: begin
            if (pend) err <= 1'b1;
            else begin
              cmd_r <= reg_wdata;
              pend <= 1'b1;
              skip_op <= held;
              byte_idx <= '0;
              bit_idx <= '0;
              st <= S_START;
            end
          end
          A_ADDR: if (!pend) addr_r <= reg_wdata[23:0];
          A_DATA: if (!pend) data_r <= reg_wdata;
          A_STAT: if (reg_wdata[29]) err <= 1'b0;
          A_TIME: if (!pend) half_r <= reg_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_r;
      A_ADDR:  reg_rdata = {8'h00, addr_r};
      A_DATA:  reg_rdata = data_r;
      A_STAT:  reg_rdata = {2'b00, err, 6'b000000, pend, 22'h0};
      A_TIME:  reg_rdata = {28'h0, half_r};
      default: reg_rdata = '0;
    endcase
  end

  assign sck_o = (st != S_LOW);
  assign mosi_o = mosi_r;
  assign cs_n_o = ~((pend | held) ? (8'b1 << cmd_r[26:24]) : 8'b0);
  assign hold_n_o = 1'b1;
  assign wp_n_o = 1'b1;
endmodule

module sflash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       sck_o,
  input logic       mosi_o,
  input logic [7:0] cs_n_o,
  input logic       pend,
  input logic       held,
  input logic       err
);
  assert_cs_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o));
  assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> sck_o);
  assert_mosi_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sck_o) |-> $stable(mosi_o));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pend) && !held) |-> &cs_n_o);
  assert_keep_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !pend) |-> !(&cs_n_o));
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(reg_we && reg_addr == 3'd0 && pend));
endmodule

bind sflash_seq sflash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
  .pend(pend), .held(held), .err(err)
);

// File: tb/sflash_seq_tb.sv
`timescale 1ns/1ps
module sflash_seq_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, miso_i = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sck_o, mosi_o, hold_n_o, wp_n_o;
  logic [7:0] cs_n_o;

  sflash_seq u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .cs_n_o(cs_n_o), .hold_n_o(hold_n_o), .wp_n_o(wp_n_o));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] cap [0:31];
  logic [7:0] resp [0:31];
  int cap_n = 0, bitc = 0, edges = 0, bad_mosi = 0;
  logic [7:0] shin = '0;
  realtime t_fall = 0, low_w = 0;

  always @(posedge sck_o) if (rst_n) begin
    shin = {shin[6:0], mosi_o};
    low_w = $realtime - t_fall;
    edges++;
    bitc++;
    if (bitc == 8) begin
      if (cap_n < 32) cap[cap_n] = shin;
      cap_n++;
      bitc = 0;
    end
  end

  always @(negedge sck_o) if (rst_n) begin
    t_fall = $realtime;
    miso_i = (cap_n < 32) ? resp[cap_n][7 - bitc] : 1'b0;
  end

  always @(mosi_o) if (rst_n) begin
    #1;
    if (sck_o) bad_mosi++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    reg_addr = 3'd3; #1; n = 0;
    while (reg_rdata[22] && n < 20000) begin @(negedge clk); #1; n++; end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input bit w, input int dl,
      input bit keep, input int dum, input int al, input int cs);
    return {5'b0, 3'(cs), 1'b0, 3'(al), 4'(dum), keep, 3'b0, 3'(dl), w, op};
  endfunction

  task automatic clr_cap();
    cap_n = 0; bitc = 0; edges = 0; bad_mosi = 0;
    for (int i = 0; i < 32; i++) resp[i] = 8'h00;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 sck idle", 32'(sck_o), 32'd1);
    chk("R1 mosi", 32'(mosi_o), 32'd1);
    chk("R1 cs_n", 32'(cs_n_o), 32'hFF);
    rd(3'd3, v);
    chk("R1 status", v, 32'h0);
    chk("R12 hold/wp", {30'h0, hold_n_o, wp_n_o}, 32'h3);
  endtask

  task automatic t_write_full();
    logic [31:0] v; int n;
    logic [7:0] ex [0:9] = '{8'h02, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
    clr_cap();
    wr(3'd4, 32'd2);
    wr(3'd1, 32'h00123456);
    wr(3'd2, 32'hDDCCBBAA);
    wr(3'd0, mk(8'h02, 1, 4, 0, 2, 3, 5));
    rd(3'd3, v);
    chk("R8 busy set", {31'h0, v[22]}, 32'd1);
    chk("R5 cs5 low", 32'(cs_n_o), 32'h000000DF);
    wait_idle(n);
    chk("R10 busy cycles", n, 10 * (16 * 3 + 1) + 1);
    chk("R2 byte count", cap_n, 10);
    for (int i = 0; i < 10; i++) chk($sformatf("R2/R3 byte %0d", i), 32'(cap[i]), 32'(ex[i]));
    chk("R5 released", 32'(cs_n_o), 32'hFF);
    chk("R10 low half width", int'(low_w), 3 * CLK_P);
    chk("R10 mosi on fall only", bad_mosi, 0);
    chk("R12 hold/wp", {30'h0, hold_n_o, wp_n_o}, 32'h3);
  endtask

  task automatic t_read();
    logic [31:0] v; int n;
    clr_cap();
    resp[3] = 8'hA1; resp[4] = 8'hB2; resp[5] = 8'hC3;
    wr(3'd4, 32'd0);
    wr(3'd2, 32'h11223344);
    wr(3'd1, 32'h0000ABCD);
    wr(3'd0, mk(8'h03, 0, 3, 0, 0, 2, 0));
    chk("R5 cs0 low", 32'(cs_n_o), 32'hFE);
    wait_idle(n);
    chk("R2 read bytes", cap_n, 6);
    chk("R2 opcode", 32'(cap[0]), 32'h03);
    chk("R2 addr hi", 32'(cap[1]), 32'hAB);
    chk("R2 addr lo", 32'(cap[2]), 32'hCD);
    rd(3'd2, v);
    chk("R4 read lanes", v, 32'h11C3B2A1);
  endtask

  task automatic t_chain();
    logic [31:0] v; int n;
    clr_cap();
    resp[5] = 8'h5A; resp[6] = 8'h6B; resp[7] = 8'h7C; resp[8] = 8'h8D;
    resp[9] = 8'hE1; resp[10] = 8'hF2;
    wr(3'd1, 32'h00000100);
    wr(3'd0, mk(8'h0B, 0, 0, 1, 1, 3, 2));
    wait_idle(n);
    chk("R5 kept low", 32'(cs_n_o), 32'hFB);
    chk("R2 chunk1 bytes", cap_n, 5);
    wr(3'd0, mk(8'h0B, 0, 4, 1, 0, 0, 2));
    wait_idle(n);
    chk("R6 no opcode resend", cap_n, 9);
    rd(3'd2, v);
    chk("R4 chunk2 data", v, 32'h8D7C6B5A);
    chk("R5 still held", 32'(cs_n_o), 32'hFB);
    wr(3'd0, mk(8'h0B, 0, 2, 0, 0, 0, 2));
    wait_idle(n);
    chk("R6 chunk3 bytes", cap_n, 11);
    rd(3'd2, v);
    chk("R4 chunk3 data", v, 32'h8D7CF2E1);
    chk("R5 chain released", 32'(cs_n_o), 32'hFF);
  endtask

  task automatic t_close_only();
    int n;
    clr_cap();
    wr(3'd0, mk(8'h06, 0, 0, 1, 0, 0, 1));
    wait_idle(n);
    chk("R5 opcode held", 32'(cs_n_o), 32'hFD);
    edges = 0;
    wr(3'd0, mk(8'h99, 0, 0, 0, 0, 0, 1));
    wait_idle(n);
    chk("R7 close cycles", n, 1);
    chk("R7 no sck edges", edges, 0);
    chk("R7 released", 32'(cs_n_o), 32'hFF);
  endtask

  task automatic t_collision();
    logic [31:0] v; int n;
    clr_cap();
    wr(3'd2, 32'h0BADF00D);
    wr(3'd4, 32'd0);
    wr(3'd0, mk(8'hC7, 1, 0, 0, 0, 0, 3));
    wr(3'd0, mk(8'h55, 1, 0, 0, 0, 0, 3));
    wr(3'd2, 32'hFFFFFFFF);
    wr(3'd4, 32'h0000000F);
    repeat (14) @(negedge clk);
    wr(3'd0, mk(8'h66, 1, 0, 0, 0, 0, 3));
    rd(3'd3, v);
    chk("R9 completion-edge write refused", {30'h0, v[29], v[22]}, 32'h2);
    chk("R9 one byte only", cap_n, 1);
    chk("R9 original opcode", 32'(cap[0]), 32'hC7);
    chk("R5 released at completion", 32'(cs_n_o), 32'hFF);
    rd(3'd2, v);
    chk("R11 data write ignored", v, 32'h0BADF00D);
    rd(3'd4, v);
    chk("R11 timing write ignored", v, 32'h0);
    wr(3'd3, 32'h0);
    rd(3'd3, v);
    chk("R8 err sticky", {31'h0, v[29]}, 32'd1);
    wr(3'd3, 32'h20000000);
    rd(3'd3, v);
    chk("R8 err cleared", {31'h0, v[29]}, 32'd0);
    wr(3'd0, mk(8'h77, 1, 0, 0, 0, 0, 3));
    rd(3'd3, v);
    chk("R9 next write accepted", {30'h0, v[29], v[22]}, 32'h1);
    wait_idle(n);
    chk("R9 accepted opcode", 32'(cap[1]), 32'h77);
  endtask

  task automatic t_clamp();
    int n;
    clr_cap();
    wr(3'd2, 32'h44332211);
    wr(3'd0, mk(8'h03, 1, 7, 0, 0, 0, 4));
    wait_idle(n);
    chk("R13 clamped length", cap_n, 5);
    chk("R13 last byte", 32'(cap[4]), 32'h44);
    chk("R3 first data byte", 32'(cap[1]), 32'h11);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_full();
    t_read();
    t_chain();
    t_close_only();
    t_collision();
    t_clamp();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule